// File: doc/BRIEF.md
# Burst Frame Serializer with Per-Byte FEC and CRC Trailer

This block assembles and shifts out the transmit frame of a 2400 bit/s data burst, one bit for each bit-clock enable. A frame opens with two 16-bit synchronisation words: first the bit-sync word, then the frame-sync word. Four control symbols follow: the station address, a format byte built from a 3-bit select, the data size, and an 8-bit checksum over those three. Every control symbol and every user data byte leaves the block as a 12-bit symbol: eight data bits, then four Hamming parity bits. The frame head is therefore exactly 80 bits long. After the head come the user data bytes, pulled from a byte stream, and then a CRC trailer.

The host sets the address, size, format select and both sync words through a small write-only register port. It then starts a burst with a one-cycle pulse. The block takes one data byte at each symbol boundary through a valid/ready pair. If no byte is offered there, the serializer stalls rather than emit filler. A busy flag covers the whole burst, and a one-cycle done pulse marks the cycle after the last CRC bit has been presented.

Top module: `burst_frame_tx`

## Requirements
- R1: After reset, `busy`, `done`, `dataReady` and `txBit` are 0. The registers reset to these values: bit-sync 16'h5555, frame-sync 16'hCB23, address 1, size 1, format select 0.
- R2: A frame is sent MSB first in this order: bit-sync word (16 bits), frame-sync word (16 bits), address symbol, format symbol, size symbol, checksum symbol. The head after the start pulse is 80 bits.
- R3: A 12-bit symbol is {d[7:0], p[3:0]}. Data bit d[i] contributes to the parity bits named by its column code, where parity bit k is set in the code when bit k of the code is 1. The column codes are d0=4'h3, d1=4'h5, d2=4'h6, d3=4'h7, d4=4'h9, d5=4'hA, d6=4'hB, d7=4'hC.
- R4: The format byte is {select[2:0], 5'b00000}. The checksum byte is (address + format + size) mod 256.
- R5: A write of 0 to the address register (cfgAddr 0) or to the size register (cfgAddr 1) is ignored, and the register keeps its previous value. The format select is at cfgAddr 2, bits 2:0.
- R6: Exactly `size` data bytes follow the head, each as a 12-bit symbol. A byte is taken on a clock edge where `bitEn`, `dataReady` and `dataValid` are all 1.
- R7: While `dataReady` is 1 and `dataValid` is 0, `bitEn` is ignored: `txBit` holds and `dataReady` stays 1.
- R8: The trailer is a CRC over the data bytes, taken MSB first, with polynomial 32'h04C11DB7, initial value 32'hFFFFFFFF, no reflection and no final inversion. With size 17 or more, all 32 bits are sent. With size 16 or less, only the upper 16 bits are sent.
- R9: `busy` is 1 from the cycle after an accepted start until the edge that presents the last trailer bit. `done` is then 1 for exactly one cycle.
- R10: While `busy` is 1, start pulses and register writes are ignored.
- R11: `txBit` changes only on an edge where `bitEn` is 1.
- R12: The bit-sync word (cfgAddr 3) and the frame-sync word (cfgAddr 4) are writable, and the written values appear in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register select: 0 address, 1 size, 2 format select, 3 bit-sync, 4 frame-sync |
| cfgWdata | input | SYNC_W (16) | Register write data |
| startIn | input | 1 | One-cycle burst start request |
| bitEn | input | 1 | Bit-clock enable, one pulse per line bit |
| dataValid | input | 1 | User data byte offered |
| dataByte | input | 8 | User data byte |
| dataReady | output | 1 | Block is waiting for a data byte at a symbol boundary |
| txBit | output | 1 | Serial line bit |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
On every cycle, the assertions check the timing rules at the ports. A done pulse lasts one cycle and coincides with the fall of busy. An accepted start raises busy. The line bit moves only on an enable edge. A waiting byte request with no byte offered freezes the line and keeps the request up. The bit content can only be shown by the bench scenarios, which compare every frame bit against a model built from the requirements. That content covers the sync words, the parity of each symbol, the checksum and format bytes, the choice between the short and long trailer at 16 and 17 bytes, rejected zero writes, and writes and starts ignored during a burst.

// File: rtl/burst_frame_pkg.sv
package burst_frame_pkg;

  localparam int BYTE_W = 8;
  localparam int PAR_W  = 4;
  localparam int SYM_W  = BYTE_W + PAR_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BSYNC, ST_FSYNC, ST_ADDR, ST_FMT,
    ST_SIZE, ST_CSUM, ST_DATA, ST_CRC
  } txState_e;

  typedef enum logic [2:0] {
    FLD_BSYNC, FLD_FSYNC, FLD_ADDR, FLD_FMT,
    FLD_SIZE, FLD_CSUM, FLD_DATA, FLD_CRC
  } field_e;

  typedef struct packed {
    logic   shift;
    logic   load;
    field_e field;
    logic   crcInit;
    logic   crcUpd;
  } strobe_t;

  // Shortened Hamming parity, columns d0..d7 = 3,5,6,7,9,A,B,C
  function automatic logic [PAR_W-1:0] parityOf(input logic [BYTE_W-1:0] d);
    return {^(d & 8'hF0), ^(d & 8'h8E), ^(d & 8'h6D), ^(d & 8'h5B)};
  endfunction

  function automatic logic [SYM_W-1:0] symbolOf(input logic [BYTE_W-1:0] d);
    return {d, parityOf(d)};
  endfunction

endpackage

// File: rtl/burst_frame_ctl.sv
module burst_frame_ctl
  import burst_frame_pkg::*;
#(
  parameter int SYNC_W      = 16,
  parameter int CRC_W       = 32,
  parameter int SHORT_CRC_W = 16,
  parameter int LONG_MIN    = 17,
  parameter int CNT_W       = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              bitEn,
  input  logic              dataValid,
  input  logic [BYTE_W-1:0] sizeVal,
  output logic              busy,
  output logic              done,
  output logic              dataReady,
  output strobe_t           stb
);

  txState_e          state, nextState;
  field_e            nextField;
  logic [CNT_W-1:0]  bitsLeft, nextWidth;
  logic [BYTE_W-1:0] bytesLeft;
  logic              lastBit, needData, step, longFrame, startNow;

  assign busy      = (state != ST_IDLE);
  assign lastBit   = (bitsLeft == CNT_W'(1));
  assign longFrame = (sizeVal >= BYTE_W'(LONG_MIN));
  assign needData  = lastBit &&
                     ((state == ST_CSUM) || ((state == ST_DATA) && (bytesLeft != '0)));
  assign dataReady = needData;
  assign step      = bitEn && busy && !(needData && !dataValid);
  assign startNow  = (state == ST_IDLE) && startIn;

  always_comb begin
    nextState = state;
    nextField = FLD_BSYNC;
    nextWidth = CNT_W'(SYM_W);
    unique case (state)
      ST_BSYNC: begin nextState = ST_FSYNC; nextField = FLD_FSYNC; nextWidth = CNT_W'(SYNC_W); end
      ST_FSYNC: begin nextState = ST_ADDR;  nextField = FLD_ADDR; end
      ST_ADDR:  begin nextState = ST_FMT;   nextField = FLD_FMT;  end
      ST_FMT:   begin nextState = ST_SIZE;  nextField = FLD_SIZE; end
      ST_SIZE:  begin nextState = ST_CSUM;  nextField = FLD_CSUM; end
      ST_CSUM:  begin nextState = ST_DATA;  nextField = FLD_DATA; end
      ST_DATA: begin
        if (bytesLeft != '0) begin
          nextState = ST_DATA;
          nextField = FLD_DATA;
        end else begin
          nextState = ST_CRC;
          nextField = FLD_CRC;
          nextWidth = longFrame ? CNT_W'(CRC_W) : CNT_W'(SHORT_CRC_W);
        end
      end
      ST_CRC:  begin nextState = ST_IDLE; nextField = FLD_CRC; end
      default: begin nextState = ST_IDLE; end
    endcase
  end

  always_comb begin
    stb.shift   = step;
    stb.load    = startNow || (step && lastBit && (state != ST_CRC));
    stb.field   = startNow ? FLD_BSYNC : nextField;
    stb.crcInit = startNow;
    stb.crcUpd  = step && needData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitsLeft  <= '0;
      bytesLeft <= '0;
      done      <= 1'b0;
    end else begin
      done <= step && lastBit && (state == ST_CRC);
      if (startNow) begin
        state     <= ST_BSYNC;
        bitsLeft  <= CNT_W'(SYNC_W);
        bytesLeft <= sizeVal;
      end else if (step) begin
        if (lastBit) begin
          state    <= nextState;
          bitsLeft <= nextWidth;
          if (needData) bytesLeft <= bytesLeft - 1'b1;
        end else begin
          bitsLeft <= bitsLeft - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/burst_frame_dp.sv
module burst_frame_dp
  import burst_frame_pkg::*;
#(
  parameter int              SYNC_W    = 16,
  parameter int              CRC_W     = 32,
  parameter int              SHREG_W   = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF,
  parameter logic [SYNC_W-1:0] BSYNC_RST = 16'h5555,
  parameter logic [SYNC_W-1:0] FSYNC_RST = 16'hCB23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [SYNC_W-1:0] cfgWdata,
  input  logic              busy,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] dataByte,
  output logic              txBit,
  output logic [BYTE_W-1:0] sizeVal
);

  localparam int FMT_SEL_W = 3;

  logic [BYTE_W-1:0]    addrReg, sizeReg, fmtByte, csumByte;
  logic [FMT_SEL_W-1:0] fmtSel;
  logic [SYNC_W-1:0]    bSync, fSync;
  logic [SHREG_W-1:0]   shReg, fieldVal;
  logic [CRC_W-1:0]     crcReg;

  assign sizeVal  = sizeReg;
  assign fmtByte  = {fmtSel, {(BYTE_W-FMT_SEL_W){1'b0}}};
  assign csumByte = addrReg + fmtByte + sizeReg;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ b[i]) r = (r << 1) ^ CRC_POLY;
      else                   r = r << 1;
    end
    return r;
  endfunction

  // Fields are left-justified so the MSB always leaves first
  always_comb begin
    unique case (stb.field)
      FLD_BSYNC: fieldVal = SHREG_W'(bSync) << (SHREG_W - SYNC_W);
      FLD_FSYNC: fieldVal = SHREG_W'(fSync) << (SHREG_W - SYNC_W);
      FLD_ADDR:  fieldVal = SHREG_W'(symbolOf(addrReg))  << (SHREG_W - SYM_W);
      FLD_FMT:   fieldVal = SHREG_W'(symbolOf(fmtByte))  << (SHREG_W - SYM_W);
      FLD_SIZE:  fieldVal = SHREG_W'(symbolOf(sizeReg))  << (SHREG_W - SYM_W);
      FLD_CSUM:  fieldVal = SHREG_W'(symbolOf(csumByte)) << (SHREG_W - SYM_W);
      FLD_DATA:  fieldVal = SHREG_W'(symbolOf(dataByte)) << (SHREG_W - SYM_W);
      default:   fieldVal = SHREG_W'(crcReg) << (SHREG_W - CRC_W);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= BYTE_W'(1);
      sizeReg <= BYTE_W'(1);
      fmtSel  <= '0;
      bSync   <= BSYNC_RST;
      fSync   <= FSYNC_RST;
    end else if (cfgWe && !busy) begin
      unique case (cfgAddr)
        3'd0: if (cfgWdata[BYTE_W-1:0] != '0) addrReg <= cfgWdata[BYTE_W-1:0];
        3'd1: if (cfgWdata[BYTE_W-1:0] != '0) sizeReg <= cfgWdata[BYTE_W-1:0];
        3'd2: fmtSel <= cfgWdata[FMT_SEL_W-1:0];
        3'd3: bSync  <= cfgWdata;
        3'd4: fSync  <= cfgWdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      txBit  <= 1'b0;
      crcReg <= CRC_INIT;
    end else begin
      if (stb.shift) txBit <= shReg[SHREG_W-1];
      if (stb.load)       shReg <= fieldVal;
      else if (stb.shift) shReg <= shReg << 1;
      if (stb.crcInit)     crcReg <= CRC_INIT;
      else if (stb.crcUpd) crcReg <= crcStep(crcReg, dataByte);
    end
  end

endmodule

// File: rtl/burst_frame_tx.sv
module burst_frame_tx
  import burst_frame_pkg::*;
#(
  parameter int SYNC_W      = 16,
  parameter int CRC_W       = 32,
  parameter int SHORT_CRC_W = 16,
  parameter int LONG_MIN    = 17,
  parameter logic [CRC_W-1:0]  CRC_POLY  = 32'h04C11DB7,
  parameter logic [CRC_W-1:0]  CRC_INIT  = 32'hFFFFFFFF,
  parameter logic [SYNC_W-1:0] BSYNC_RST = 16'h5555,
  parameter logic [SYNC_W-1:0] FSYNC_RST = 16'hCB23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [SYNC_W-1:0] cfgWdata,
  input  logic              startIn,
  input  logic              bitEn,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  output logic              dataReady,
  output logic              txBit,
  output logic              busy,
  output logic              done
);

  localparam int WIDE_W  = (CRC_W > SYNC_W) ? CRC_W : SYNC_W;
  localparam int SHREG_W = (WIDE_W > SYM_W) ? WIDE_W : SYM_W;
  localparam int CNT_W   = $clog2(SHREG_W + 1);

  strobe_t           stb;
  logic [BYTE_W-1:0] sizeVal;

  burst_frame_ctl #(
    .SYNC_W(SYNC_W), .CRC_W(CRC_W), .SHORT_CRC_W(SHORT_CRC_W),
    .LONG_MIN(LONG_MIN), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .bitEn(bitEn),
    .dataValid(dataValid), .sizeVal(sizeVal), .busy(busy), .done(done),
    .dataReady(dataReady), .stb(stb)
  );

  burst_frame_dp #(
    .SYNC_W(SYNC_W), .CRC_W(CRC_W), .SHREG_W(SHREG_W),
    .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT),
    .BSYNC_RST(BSYNC_RST), .FSYNC_RST(FSYNC_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .busy(busy), .stb(stb), .dataByte(dataByte),
    .txBit(txBit), .sizeVal(sizeVal)
  );

endmodule

// File: rtl/burst_frame_chk.sv
module burst_frame_chk (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic bitEn,
  input logic dataValid,
  input logic dataReady,
  input logic txBit,
  input logic busy,
  input logic done
);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));

  // R9
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busy) |=> busy);

  // R10
  start_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && busy && !bitEn) |=> busy);

  // R11
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && !dataValid) |=> (dataReady && $stable(txBit)));

  // R6
  request_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> busy);

endmodule

bind burst_frame_tx burst_frame_chk u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .bitEn(bitEn),
  .dataValid(dataValid), .dataReady(dataReady), .txBit(txBit),
  .busy(busy), .done(done)
);

// File: tb/burst_frame_tx_tb.sv
`timescale 1ns/1ps
module burst_frame_tx_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgWdata = '0;
  logic        startIn = 1'b0;
  logic        bitEn = 1'b0;
  logic        dataValid = 1'b0;
  logic [7:0]  dataByte = '0;
  logic        dataReady, txBit, busy, done;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mAddr, mSize;
  logic [2:0]  mFmt;
  logic [15:0] mBs, mFs;
  logic [7:0]  dataMem [0:255];
  logic        expBits [0:4095];
  int          expLen;
  int          dataIdx;

  always #2.5 clk = ~clk;

  burst_frame_tx u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .startIn(startIn), .bitEn(bitEn),
    .dataValid(dataValid), .dataByte(dataByte), .dataReady(dataReady),
    .txBit(txBit), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] refParity(input logic [7:0] d);
    logic [3:0] p = '0;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] col;
      case (i)
        0: col = 4'h3; 1: col = 4'h5; 2: col = 4'h6; 3: col = 4'h7;
        4: col = 4'h9; 5: col = 4'hA; 6: col = 4'hB; default: col = 4'hC;
      endcase
      if (d[i]) p = p ^ col;
    end
    return p;
  endfunction

  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[31] ^ b[i];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic addBits(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      expBits[expLen] = v[i];
      expLen++;
    end
  endtask

  task automatic addSym(input logic [7:0] d);
    addBits({20'd0, d, refParity(d)}, 12);
  endtask

  task automatic modelDefaults();
    mAddr = 8'd1; mSize = 8'd1; mFmt = 3'd0; mBs = 16'h5555; mFs = 16'hCB23;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelDefaults();
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [15:0] v, input bit updModel);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
    if (updModel) begin
      case (a)
        3'd0: if (v[7:0] != 0) mAddr = v[7:0];
        3'd1: if (v[7:0] != 0) mSize = v[7:0];
        3'd2: mFmt = v[2:0];
        3'd3: mBs = v;
        3'd4: mFs = v;
        default: ;
      endcase
    end
  endtask

  task automatic pulseBit(output logic b);
    logic take;
    @(negedge clk);
    take = dataReady && dataValid;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    if (take) begin
      dataIdx++;
      dataByte = dataMem[dataIdx[7:0]];
    end
    b = txBit;
  endtask

  task automatic runFrame(input string req, input int seed, input bit doStall,
                          input bit doPoke);
    logic [31:0] crc;
    logic [7:0]  fmtByte;
    logic        b, hold;
    int          bad, firstBad;
    bit          stalled;
    fmtByte = {mFmt, 5'b0};
    for (int i = 0; i < 256; i++) dataMem[i] = 8'(i * 37 + seed);
    expLen = 0;
    addBits({16'd0, mBs}, 16);
    addBits({16'd0, mFs}, 16);
    addSym(mAddr);
    addSym(fmtByte);
    addSym(mSize);
    addSym(8'(mAddr + fmtByte + mSize));
    crc = 32'hFFFFFFFF;
    for (int i = 0; i < int'(mSize); i++) begin
      addSym(dataMem[i]);
      crc = refCrc(crc, dataMem[i]);
    end
    if (mSize > 8'd16) addBits(crc, 32);
    else               addBits({16'd0, crc[31:16]}, 16);

    dataIdx = 0; dataByte = dataMem[0]; dataValid = 1'b1;
    @(negedge clk); startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
    check(busy === 1'b1, "R9", {req, " busy after start"}, busy, 1);
    bad = 0; firstBad = -1; stalled = 0;
    for (int k = 0; k < expLen; k++) begin
      if (doStall && !stalled && dataReady) begin
        stalled = 1;
        dataValid = 1'b0;
        hold = txBit;
        for (int s = 0; s < 3; s++) pulseBit(b);
        check(txBit === hold && dataReady === 1'b1 && busy === 1'b1, "R7",
              "stall holds line", {txBit, dataReady, busy}, {hold, 2'b11});
        dataValid = 1'b1;
      end
      if (doPoke && k == 40) begin
        @(negedge clk); startIn = 1'b1;
        @(negedge clk); startIn = 1'b0;
        cfgWrite(3'd0, 16'h0077, 1'b0);
        cfgWrite(3'd1, 16'h0009, 1'b0);
      end
      pulseBit(b);
      if (b !== expBits[k]) begin
        bad++;
        if (firstBad < 0) firstBad = k;
      end
    end
    check(bad == 0, req, $sformatf("frame bits wrong, first at bit %0d", firstBad), bad, 0);
    check(dataIdx == int'(mSize), "R6", {req, " bytes taken"}, dataIdx, int'(mSize));
    check(busy === 1'b0 && done === 1'b1, "R9", {req, " end of burst"}, {busy, done}, 2'b01);
    @(negedge clk);
    check(done === 1'b0, "R9", {req, " done width"}, done, 0);
  endtask

  task automatic t_reset();
    doReset();
    check(busy === 1'b0 && done === 1'b0 && dataReady === 1'b0 && txBit === 1'b0,
          "R1", "idle outputs after reset", {busy, done, dataReady, txBit}, 0);
    runFrame("R1 R2 R3 R4 R8 default frame", 3, 0, 0);
  endtask

  task automatic t_long();
    cfgWrite(3'd0, 16'h004F, 1);
    cfgWrite(3'd1, 16'd20, 1);
    cfgWrite(3'd2, 16'h0005, 1);
    runFrame("R2 R3 R4 R6 R8 long frame", 11, 0, 0);
  endtask

  task automatic t_boundary();
    cfgWrite(3'd1, 16'd16, 1);
    runFrame("R8 size16 short trailer", 90, 0, 0);
    cfgWrite(3'd1, 16'd17, 1);
    runFrame("R8 size17 long trailer", 91, 0, 0);
  endtask

  task automatic t_reject();
    cfgWrite(3'd0, 16'h00C3, 1);
    cfgWrite(3'd1, 16'd4, 1);
    cfgWrite(3'd0, 16'h0000, 1);
    cfgWrite(3'd1, 16'h0000, 1);
    runFrame("R5 zero writes ignored", 5, 0, 0);
  endtask

  task automatic t_stall();
    cfgWrite(3'd1, 16'd3, 1);
    runFrame("R7 R11 stall at boundary", 44, 1, 0);
  endtask

  task automatic t_busyIgnore();
    cfgWrite(3'd0, 16'h0021, 1);
    cfgWrite(3'd1, 16'd2, 1);
    runFrame("R10 start and writes during burst", 7, 0, 1);
    runFrame("R10 registers unchanged after burst", 8, 0, 0);
  endtask

  task automatic t_sync();
    cfgWrite(3'd3, 16'h1234, 1);
    cfgWrite(3'd4, 16'hABCD, 1);
    cfgWrite(3'd2, 16'h0007, 1);
    runFrame("R12 programmed sync words", 60, 0, 0);
    doReset();
    runFrame("R1 defaults restored by reset", 61, 0, 0);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    finishRun();
  end

  initial begin
    modelDefaults();
    t_reset();
    t_long();
    t_boundary();
    t_reject();
    t_stall();
    t_busyIgnore();
    t_sync();
    finishRun();
  end

endmodule